// File: doc/BRIEF.md
# Triangular-Window Decimation-Free Smoothing Filter

This block smooths a stream of signed samples from a rate sensor. Every accepted sample passes through two identical running-average stages of equal length N = 2^m. Two rectangular windows in series give a triangular impulse response that is 2N−1 samples long. The output keeps the input rate: one filtered word comes out for each accepted sample. This lets the sensor front end trade noise against response time without changing its sample schedule.

The block holds its own copy of two configuration fields: a 3-bit tap exponent and a 3-bit measurement-range code. The range code puts a floor under the exponent. The finer ranges need more averaging to keep their resolution, so the exponent actually used is the larger of the programmed value and that floor. Any change to either field restarts the filter from empty histories. No output is flagged valid until enough new samples have arrived to fill the whole triangular window.

Top module: `tri_fir_filter`

## Requirements
- R1: While `rst` is high and on the clock after it, `out_vld_o` is low. Reset loads the held configuration with exponent 2 and range code 3'b100. When the inputs already match these defaults after reset, the first valid output therefore follows the 7th accepted sample.
- R2: Each stage keeps the last N = 2^m samples it received, with samples never received counted as zero. It outputs their sum arithmetically shifted right by m. The final output is the second stage applied to the first stage's outputs, so a constant input value v appears unchanged as v once the window is full.
- R3: When the range code is 3'b010, the exponent used is max(tap field, 2).
- R4: When the range code is 3'b001, the exponent used is max(tap field, 4).
- R5: For range code 3'b100, and for any other code, the tap field is used as given (0 to 7, up to 128 taps).
- R6: In any cycle where the tap or range input differs from the held copy, the held copy takes the new value and both stage histories and sums are emptied. A sample strobe in that cycle is discarded. No result in flight is flagged valid, so `out_vld_o` is low on the next two clocks.
- R7: `out_vld_o` pulses once for each accepted sample whose count since the last clear is at least 2N−1, and never otherwise.
- R8: A sample accepted at a clock edge appears on `out_dat_o` two clock edges later. With exponent 0, the output equals that input sample.
- R9: The right shift rounds toward minus infinity. Inputs alternating −1, 0 at exponent 1 settle at −1, and inputs alternating 1, 0 settle at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_i | input | 14 | Signed input sample, two's complement |
| smp_vld_i | input | 1 | Sample strobe: `smp_i` is taken in this cycle |
| tap_exp_i | input | 3 | Tap exponent m; each stage averages 2^m samples |
| range_i | input | 3 | Range code: 3'b100 wide, 3'b010 medium, 3'b001 fine |
| out_dat_o | output | 14 | Signed filtered sample |
| out_vld_o | output | 1 | One-cycle pulse marking a valid `out_dat_o` |

## Verification
Four things are checked by assertions on every cycle:
- the output stays quiet during and right after reset;
- a valid output always traces back to a sample strobe exactly two clocks earlier;
- a change of configuration silences the output for the next two clocks;
- at exponent 0 in the wide range, the output is the input delayed by two clocks.

The floor that each range code puts under the exponent, the exact onset after 2N−1 samples, the arithmetic of the averages and the rounding toward minus infinity can only be shown by the bench's scenarios. The bench checks these against a behavioural queue model, cycle by cycle, over fixed and random sample streams.

// File: rtl/tri_fir_pkg.sv
package tri_fir_pkg;

    localparam int SMP_W   = 14;
    localparam int EXP_W   = 3;
    localparam int RNG_W   = 3;
    localparam int MAX_EXP = (1 << EXP_W) - 1;
    localparam int N_STAGE = 2;

    typedef logic [EXP_W-1:0] exp_t;
    typedef logic [RNG_W-1:0] rng_t;

    typedef enum logic [RNG_W-1:0] {
        RNG_WIDE = 3'b100,
        RNG_MID  = 3'b010,
        RNG_FINE = 3'b001
    } rng_e;

    typedef struct packed {
        exp_t tap;
        rng_t rng;
    } cfg_t;

    localparam exp_t TAP_RST = 3'd2;
    localparam rng_t RNG_RST = RNG_WIDE;

    function automatic exp_t range_floor(rng_t r);
        exp_t f;
        case (r)
            RNG_MID:  f = 3'd2;
            RNG_FINE: f = 3'd4;
            default:  f = 3'd0;
        endcase
        return f;
    endfunction

    function automatic exp_t eff_exp(cfg_t c);
        exp_t f;
        f = range_floor(c.rng);
        return (c.tap < f) ? f : c.tap;
    endfunction

endpackage

// File: rtl/tri_fir_cfg.sv
module tri_fir_cfg
    import tri_fir_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  exp_t tap_i,
    input  rng_t rng_i,
    input  logic smp_vld_i,
    output logic flush_o,
    output logic accept_o,
    output exp_t m_o
);

    cfg_t held_q;
    cfg_t req;

    assign req = '{tap: tap_i, rng: rng_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '{tap: TAP_RST, rng: RNG_RST};
        end else begin
            held_q <= req;
        end
    end

    always_comb begin
        flush_o  = (req != held_q);
        accept_o = smp_vld_i && !flush_o && !rst;
        m_o      = eff_exp(held_q);
    end

endmodule

// File: rtl/tri_fir_stage.sv
module tri_fir_stage
    import tri_fir_pkg::*;
#(
    parameter int DW    = SMP_W,
    parameter int MAX_M = MAX_EXP
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  exp_t                 m,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_dat,
    output logic                 out_vld,
    output logic signed [DW-1:0] out_dat
);

    localparam int DEPTH = 1 << MAX_M;
    localparam int PW    = MAX_M;
    localparam int SW    = DW + MAX_M;

    logic signed [DW-1:0] hist [DEPTH];
    logic [PW-1:0]        ptr_q;
    logic [PW-1:0]        ptr_nx;
    logic [PW:0]          fill_q;
    logic [PW:0]          span;
    logic [PW:0]          mask_w;
    logic                 full;
    logic                 take;
    logic signed [DW-1:0] oldest;
    logic signed [SW-1:0] acc_q;
    logic signed [SW-1:0] acc_nx;
    logic signed [SW-1:0] in_ext;
    logic signed [SW-1:0] old_ext;
    logic signed [SW-1:0] scaled;

    always_comb begin
        span    = (PW+1)'(1) << m;
        mask_w  = span - (PW+1)'(1);
        full    = (fill_q == span);
        take    = in_vld && !flush && !rst;
        oldest  = full ? hist[ptr_q] : '0;
        in_ext  = SW'(in_dat);
        old_ext = SW'(oldest);
        acc_nx  = acc_q + in_ext - old_ext;
        scaled  = acc_nx >>> m;
        ptr_nx  = (ptr_q + PW'(1)) & mask_w[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr_q   <= '0;
            fill_q  <= '0;
            acc_q   <= '0;
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                ptr_q   <= ptr_nx;
                fill_q  <= full ? fill_q : fill_q + (PW+1)'(1);
                acc_q   <= acc_nx;
                out_dat <= scaled[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            hist[ptr_q] <= in_dat;
        end
    end

endmodule

// File: rtl/tri_fir_gate.sv
module tri_fir_gate
    import tri_fir_pkg::*;
#(
    parameter int MAX_M  = MAX_EXP,
    parameter int STAGES = N_STAGE
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic accept,
    input  exp_t m,
    input  logic last_vld,
    output logic out_vld
);

    localparam int CW = MAX_M + 2;

    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     target;
    logic              ready;
    logic [STAGES-1:0] tag_q;

    always_comb begin
        target = (CW'(2) << m) - CW'(1);
        ready  = (cnt_q + CW'(1)) >= target;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt_q <= '0;
            tag_q <= '0;
        end else begin
            if (accept && cnt_q != target) begin
                cnt_q <= cnt_q + CW'(1);
            end
            tag_q[0] <= accept && ready;
            for (int i = 1; i < STAGES; i++) begin
                tag_q[i] <= tag_q[i-1];
            end
        end
    end

    assign out_vld = last_vld && tag_q[STAGES-1];

endmodule

// File: rtl/tri_fir_filter.sv
module tri_fir_filter
    import tri_fir_pkg::*;
#(
    parameter int DW     = SMP_W,
    parameter int MAX_M  = MAX_EXP,
    parameter int STAGES = N_STAGE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] smp_i,
    input  logic          smp_vld_i,
    input  logic [2:0]    tap_exp_i,
    input  logic [2:0]    range_i,
    output logic [DW-1:0] out_dat_o,
    output logic          out_vld_o
);

    logic                 flush;
    logic                 accept;
    exp_t                 m_eff;
    logic [STAGES:0]      vld_c;
    logic signed [DW-1:0] dat_c [STAGES+1];

    tri_fir_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .tap_i     (tap_exp_i),
        .rng_i     (range_i),
        .smp_vld_i (smp_vld_i),
        .flush_o   (flush),
        .accept_o  (accept),
        .m_o       (m_eff)
    );

    assign vld_c[0] = accept;
    assign dat_c[0] = $signed(smp_i);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        tri_fir_stage #(
            .DW    (DW),
            .MAX_M (MAX_M)
        ) u_stg (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .m       (m_eff),
            .in_vld  (vld_c[g]),
            .in_dat  (dat_c[g]),
            .out_vld (vld_c[g+1]),
            .out_dat (dat_c[g+1])
        );
    end

    tri_fir_gate #(
        .MAX_M  (MAX_M),
        .STAGES (STAGES)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .accept   (accept),
        .m        (m_eff),
        .last_vld (vld_c[STAGES]),
        .out_vld  (out_vld_o)
    );

    assign out_dat_o = dat_c[STAGES];

endmodule

// File: rtl/tri_fir_checker.sv
module tri_fir_checker #(
    parameter int DW = 14
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] smp_i,
    input logic          smp_vld_i,
    input logic [2:0]    tap_exp_i,
    input logic [2:0]    range_i,
    input logic [DW-1:0] out_dat_o,
    input logic          out_vld_o
);

    // R1: output quiet while in reset and on the clock after it
    p_quiet_reset_r1: assert property (@(posedge clk)
        rst |=> !out_vld_o);

    // R6: configuration change silences the next output
    p_flush_next_r6: assert property (@(posedge clk) disable iff (rst)
        (tap_exp_i != $past(tap_exp_i) || range_i != $past(range_i)) |=> !out_vld_o);

    // R6: and the one after it (in-flight result dropped)
    p_flush_inflight_r6: assert property (@(posedge clk) disable iff (rst)
        (tap_exp_i != $past(tap_exp_i) || range_i != $past(range_i)) |-> ##2 !out_vld_o);

    // R7: every valid output stems from a strobe two clocks earlier
    p_vld_has_src_r7: assert property (@(posedge clk) disable iff (rst)
        out_vld_o |-> $past(smp_vld_i, 2));

    // R8: zero exponent in the wide range is a two-clock delay line
    p_passthru_r8: assert property (@(posedge clk) disable iff (rst)
        (out_vld_o && $past(tap_exp_i, 2) == 3'd0 && $past(range_i, 2) == 3'b100)
        |-> out_dat_o == $past(smp_i, 2));

endmodule

bind tri_fir_filter tri_fir_checker #(.DW(DW)) u_chk (.*);

// File: tb/tri_fir_filter_tb_top.sv
module tri_fir_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 14;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] smp;
    logic          smp_vld;
    logic [2:0]    tap;
    logic [2:0]    rng;
    logic [DW-1:0] out_dat;
    logic          out_vld;

    int n_checks = 0;
    int n_fail   = 0;

    int tq, rq, acc_cnt;
    int h1[$];
    int h2[$];
    bit p1v, p2v;
    int p1d, p2d;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_fir_filter dut_i (
        .clk       (clk),
        .rst       (rst),
        .smp_i     (smp),
        .smp_vld_i (smp_vld),
        .tap_exp_i (tap),
        .range_i   (rng),
        .out_dat_o (out_dat),
        .out_vld_o (out_vld)
    );

    function automatic int model_m(int t, int r);
        int f;
        f = (r == 2) ? 2 : (r == 1) ? 4 : 0;
        return (t < f) ? f : t;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic model_clear();
        h1.delete();
        h2.delete();
        acc_cnt = 0;
        p1v = 0;
        p2v = 0;
    endtask

    task automatic push_avg(ref int q[$], input int x, input int m, output int y);
        int s;
        q.push_front(x);
        while (q.size() > (1 << m)) void'(q.pop_back());
        s = 0;
        foreach (q[i]) s += q[i];
        y = s >>> m;
    endtask

    function automatic int sdat();
        return int'($signed(out_dat));
    endfunction

    // one clock: drive, update model at the edge, compare at negedge
    task automatic step(bit v, int d);
        int m, y1, y2;
        smp_vld = v;
        smp     = d[DW-1:0];
        @(posedge clk);
        p2v = p1v;
        p2d = p1d;
        p1v = 0;
        if (rst) begin
            tq = 2;
            rq = 4;
            model_clear();
        end else if (int'(tap) != tq || int'(rng) != rq) begin
            tq = int'(tap);
            rq = int'(rng);
            model_clear();
        end else if (v) begin
            m = model_m(tq, rq);
            acc_cnt++;
            push_avg(h1, int'($signed(smp)), m, y1);
            push_avg(h2, y1, m, y2);
            p1v = (acc_cnt >= 2 * (1 << m) - 1);
            p1d = y2;
        end
        @(negedge clk);
        chk(out_vld == p2v, "R7 valid", int'(out_vld), int'(p2v));
        if (p2v) chk(sdat() == p2d, "R2 data", sdat(), p2d);
    endtask

    // count samples until first valid output; expect 2N-1 and constant value
    task automatic onset(int t, int r, int expn, string req, int val);
        int found;
        found = -1;
        tap = t[2:0];
        rng = r[2:0];
        step(0, 0);
        for (int i = 1; i <= 600; i++) begin
            step(1, val);
            if (out_vld) begin
                found = i - 1;
                break;
            end
        end
        chk(found == expn, req, found, expn);
        chk(sdat() == val, "R2 constant", sdat(), val);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int a, prev;
        rst = 1; smp_vld = 0; smp = '0; tap = 3'd2; rng = 3'b100;
        tq = 2; rq = 4; model_clear();
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            step(1, 55);
            chk(out_vld == 1'b0, "R1 reset", int'(out_vld), 0);
        end
        rst = 0;
        onset(2, 4, 7, "R1 default onset", 300);

        // R8 pass-through at exponent 0
        onset(0, 4, 1, "R8 onset", -20);
        prev = 8191;
        step(1, prev);
        for (int i = 0; i < 8; i++) begin
            a = (i % 2 == 0) ? -8192 + i : 8191 - 3 * i;
            step(1, a);
            chk(sdat() == prev, "R8 pass", sdat(), prev);
            prev = a;
        end

        // R3 / R4 / R5 range floors
        onset(0, 2, 7,   "R3 floor", -77);
        onset(3, 2, 15,  "R3 above", 1234);
        onset(1, 1, 31,  "R4 floor", -4000);
        onset(6, 1, 127, "R4 above", 17);
        onset(1, 7, 3,   "R5 other code", 9);
        onset(7, 4, 255, "R5 max", -8192);
        onset(5, 4, 63,  "R5 mid", 8191);

        // R9 rounding toward minus infinity
        tap = 3'd1; rng = 3'b100;
        step(0, 0);
        for (int i = 0; i < 20; i++) step(1, (i % 2 == 0) ? -1 : 0);
        chk(sdat() == -1, "R9 negative", sdat(), -1);
        for (int i = 0; i < 10; i++) step(1, (i % 2 == 0) ? 1 : 0);
        chk(sdat() == 0, "R9 positive", sdat(), 0);

        // R6 flush on configuration change
        for (int i = 0; i < 10; i++) step(1, 1000);
        tap = 3'd2;
        step(1, 1000);
        chk(out_vld == 1'b0, "R6 flush", int'(out_vld), 0);
        for (int i = 1; i <= 7; i++) begin
            step(1, 50);
            if (i == 1) chk(out_vld == 1'b0, "R6 in-flight", int'(out_vld), 0);
        end
        step(0, 0);
        chk(out_vld == 1'b1, "R6 refill valid", int'(out_vld), 1);
        chk(sdat() == 50, "R6 history cleared", sdat(), 50);

        // random streams, gaps and occasional reconfiguration (R2, R7)
        for (int k = 0; k < 6; k++) begin
            tap = 3'($urandom_range(0, 3));
            rng = (k % 3 == 0) ? 3'b100 : (k % 3 == 1) ? 3'b010 : 3'b001;
            for (int i = 0; i < 300; i++) begin
                step(($urandom_range(0, 9) < 7), int'($urandom_range(0, 16383)) - 8192);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule